// File: doc/BRIEF.md
# Compact Branch Next-PC Unit

This unit works out where fetch goes after a compact control-transfer instruction in a 64-bit RISC pipeline. Compact branches and jumps have no delay slot, so the instruction that follows one in memory is never executed. The unit takes one instruction per cycle with its program counter and the two register operands already read for its rs and rt fields. One cycle later it presents the next PC, a redirect flag for fetch, and a request to write the return address into the link register.

Four opcodes are decoded. Two carry a 26-bit word offset: a plain branch and a branch-and-link. The other two are shared opcodes, and the rs field number (not the value of the register) picks the form. A nonzero field number gives a compare-to-zero branch with a 21-bit word offset. A zero field number gives a jump to the rt operand plus a 16-bit immediate. Any other opcode falls through to the sequential address.

Field positions: opcode in bits 31:26, rs field in 25:21, rt field in 20:16, a 16-bit immediate in 15:0, a 21-bit offset in 20:0 and a 26-bit offset in 25:0. All offsets and immediates are two's complement.

Top module: `cbr_nextpc`

## Requirements
- R1: While `rst` is high at a rising edge, every output is zero after that edge.
- R2: Each output register is loaded from the inputs present at the previous rising edge. When `i_valid` was low there, every output is zero.
- R3: Opcode 6'h32 sets the next PC to PC+4 plus the sign-extended 26-bit offset times 4, with no link write.
- R4: Opcode 6'h3A computes the same target as R3, sets `o_link_we`, sets `o_link_idx` to 31 and sets `o_link_data` to PC+4.
- R5: Opcode 6'h36 with a nonzero rs field number sets the next PC to PC+4 plus the sign-extended 21-bit offset times 4 when `i_rs_val` is zero, and to PC+4 otherwise.
- R6: Opcode 6'h36 with rs field number 0 sets the next PC to `i_rt_val` plus the sign-extended 16-bit immediate, with no link write.
- R7: Opcode 6'h3E with a nonzero rs field number branches as in R5, but only when `i_rs_val` is nonzero.
- R8: Opcode 6'h3E with rs field number 0 jumps as in R6 and also writes the link exactly as R4 does.
- R9: `o_redirect` is high exactly when the output is valid and the next PC differs from PC+4. This includes a zero offset and addition that wraps at 64 bits.
- R10: A valid instruction with any other opcode gives a next PC of PC+4, with no redirect and no link write.
- R11: The conditional forms never request a link write, whether or not the branch is taken. When `o_link_we` is low, `o_link_idx` and `o_link_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Instruction present this cycle |
| i_pc | input | 64 | Address of the instruction |
| i_instr | input | 32 | Instruction word |
| i_rs_val | input | 64 | Operand read for the rs field |
| i_rt_val | input | 64 | Operand read for the rt field |
| o_valid | output | 1 | Result valid |
| o_next_pc | output | 64 | Address to fetch next |
| o_redirect | output | 1 | Next PC is not sequential |
| o_link_we | output | 1 | Write the link register |
| o_link_idx | output | 5 | Link register number (31) |
| o_link_data | output | 64 | Return address PC+4 |

## Verification
Every result is due exactly one rising edge after its inputs are presented, because the whole path ends in a single output register. The bench drives new inputs on the falling edge. On the next falling edge it compares all outputs against the values its behavioural model computed when those inputs were driven, so each comparison covers exactly one register stage. Directed cases cover zero and extreme offsets, a wrap at the top of the address space, both values of the rs field number on each shared opcode, and an invalid cycle. Random instructions then follow.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    localparam int ILEN = 32;

    localparam logic [5:0] OP_BR26   = 6'h32;
    localparam logic [5:0] OP_BRL26  = 6'h3A;
    localparam logic [5:0] OP_SHR_EZ = 6'h36;
    localparam logic [5:0] OP_SHR_NZ = 6'h3E;

    localparam logic [4:0] LINK_REG = 5'd31;

    typedef enum logic [2:0] {
        K_SEQ,
        K_REL26,
        K_IFZERO,
        K_IFNZERO,
        K_INDEX
    } kind_e;

    typedef struct packed {
        kind_e       kind;
        logic        link;
        logic [25:0] off26;
        logic [20:0] off21;
        logic [15:0] imm16;
    } dec_t;

    function automatic logic [5:0] opcode_of(input logic [ILEN-1:0] w);
        return w[31:26];
    endfunction

    function automatic logic [4:0] rsnum_of(input logic [ILEN-1:0] w);
        return w[25:21];
    endfunction

endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
    import cbr_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    output dec_t            dec
);
    logic [5:0] op;
    logic       rs_zero;

    assign op      = opcode_of(instr);
    assign rs_zero = (rsnum_of(instr) == 5'd0);

    always_comb begin
        dec.off26 = instr[25:0];
        dec.off21 = instr[20:0];
        dec.imm16 = instr[15:0];
        dec.kind  = K_SEQ;
        dec.link  = 1'b0;
        unique case (op)
            OP_BR26:   dec.kind = K_REL26;
            OP_BRL26: begin
                dec.kind = K_REL26;
                dec.link = 1'b1;
            end
            OP_SHR_EZ: dec.kind = rs_zero ? K_INDEX : K_IFZERO;
            OP_SHR_NZ: begin
                dec.kind = rs_zero ? K_INDEX : K_IFNZERO;
                dec.link = rs_zero;
            end
            default:   dec.kind = K_SEQ;
        endcase
    end
endmodule

// File: rtl/cbr_target.sv
module cbr_target
    import cbr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  dec_t            dec,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic [XLEN-1:0] seq_pc,
    output logic [XLEN-1:0] next_pc,
    output logic            link_we,
    output logic [XLEN-1:0] link_data
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] sx26, sx21, sx16;
    logic [XLEN-1:0] tgt26, tgt21, tgtidx;
    logic            rs_is_zero;

    assign sx26 = {{(XLEN-26){dec.off26[25]}}, dec.off26};
    assign sx21 = {{(XLEN-21){dec.off21[20]}}, dec.off21};
    assign sx16 = {{(XLEN-16){dec.imm16[15]}}, dec.imm16};

    assign seq_pc     = pc + STEP;
    assign tgt26      = seq_pc + (sx26 << 2);
    assign tgt21      = seq_pc + (sx21 << 2);
    assign tgtidx     = rt_val + sx16;
    assign rs_is_zero = (rs_val == '0);

    always_comb begin
        unique case (dec.kind)
            K_REL26:   next_pc = tgt26;
            K_IFZERO:  next_pc = rs_is_zero ? tgt21 : seq_pc;
            K_IFNZERO: next_pc = rs_is_zero ? seq_pc : tgt21;
            K_INDEX:   next_pc = tgtidx;
            default:   next_pc = seq_pc;
        endcase
    end

    assign link_we   = dec.link;
    assign link_data = dec.link ? seq_pc : '0;
endmodule

// File: rtl/cbr_nextpc.sv
module cbr_nextpc
    import cbr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            i_valid,
    input  logic [XLEN-1:0] i_pc,
    input  logic [31:0]     i_instr,
    input  logic [XLEN-1:0] i_rs_val,
    input  logic [XLEN-1:0] i_rt_val,
    output logic            o_valid,
    output logic [XLEN-1:0] o_next_pc,
    output logic            o_redirect,
    output logic            o_link_we,
    output logic [4:0]      o_link_idx,
    output logic [XLEN-1:0] o_link_data
);
    dec_t            dec;
    logic [XLEN-1:0] seq_pc, nxt, ldata;
    logic            lwe;

    cbr_decode u_dec (
        .instr (i_instr),
        .dec   (dec)
    );

    cbr_target #(.XLEN(XLEN)) u_tgt (
        .dec       (dec),
        .pc        (i_pc),
        .rs_val    (i_rs_val),
        .rt_val    (i_rt_val),
        .seq_pc    (seq_pc),
        .next_pc   (nxt),
        .link_we   (lwe),
        .link_data (ldata)
    );

    always_ff @(posedge clk) begin
        if (rst || !i_valid) begin
            o_valid     <= 1'b0;
            o_next_pc   <= '0;
            o_redirect  <= 1'b0;
            o_link_we   <= 1'b0;
            o_link_idx  <= '0;
            o_link_data <= '0;
        end else begin
            o_valid     <= 1'b1;
            o_next_pc   <= nxt;
            o_redirect  <= (nxt != seq_pc);
            o_link_we   <= lwe;
            o_link_idx  <= lwe ? LINK_REG : 5'd0;
            o_link_data <= ldata;
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        i_valid |=> o_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !o_valid |-> (!o_redirect && !o_link_we));

    // R9
    redirect_def_chk: assert property (@(posedge clk) disable iff (rst)
        o_valid |-> (o_redirect == (o_next_pc != $past(i_pc) + XLEN'(4))));

    // R4
    link_value_chk: assert property (@(posedge clk) disable iff (rst)
        o_link_we |-> (o_link_data == $past(i_pc) + XLEN'(4) && o_link_idx == 5'd31));

    // R11
    link_source_chk: assert property (@(posedge clk) disable iff (rst)
        o_link_we |-> ($past(i_instr[31:26]) == OP_BRL26 ||
                       ($past(i_instr[31:26]) == OP_SHR_NZ && $past(i_instr[25:21]) == 5'd0)));
endmodule

// File: tb/tb_cbr_nextpc.sv
`timescale 1ns/1ps
module tb_cbr_nextpc;
    localparam logic [5:0] T_BR   = 6'h32;
    localparam logic [5:0] T_BRL  = 6'h3A;
    localparam logic [5:0] T_EZ   = 6'h36;
    localparam logic [5:0] T_NZ   = 6'h3E;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        i_valid = 1'b0;
    logic [63:0] i_pc = '0;
    logic [31:0] i_instr = '0;
    logic [63:0] i_rs_val = '0;
    logic [63:0] i_rt_val = '0;
    logic        o_valid, o_redirect, o_link_we;
    logic [63:0] o_next_pc, o_link_data;
    logic [4:0]  o_link_idx;

    always #2.5 clk = ~clk;

    cbr_nextpc dut (
        .clk(clk), .rst(rst), .i_valid(i_valid), .i_pc(i_pc), .i_instr(i_instr),
        .i_rs_val(i_rs_val), .i_rt_val(i_rt_val), .o_valid(o_valid),
        .o_next_pc(o_next_pc), .o_redirect(o_redirect), .o_link_we(o_link_we),
        .o_link_idx(o_link_idx), .o_link_data(o_link_data)
    );

    int compared = 0;
    int mismatched = 0;

    logic        e_valid = 1'b0, e_redir = 1'b0, e_lwe = 1'b0;
    logic [63:0] e_next = '0, e_ldata = '0;
    logic [4:0]  e_lidx = '0;
    string       e_tag = "R1";

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    // Behavioural model of the requirements.
    task automatic model();
        longint unsigned pc, seq, tgt;
        logic [5:0] op;
        logic [4:0] rsn;
        logic link;
        pc   = i_pc;
        seq  = pc + 64'd4;
        op   = i_instr[31:26];
        rsn  = i_instr[25:21];
        link = 1'b0;
        if (rst) begin
            e_valid = 0; e_next = 0; e_redir = 0; e_lwe = 0; e_lidx = 0; e_ldata = 0;
            e_tag = "R1";
            return;
        end
        if (!i_valid) begin
            e_valid = 0; e_next = 0; e_redir = 0; e_lwe = 0; e_lidx = 0; e_ldata = 0;
            e_tag = "R2";
            return;
        end
        tgt = seq;
        if (op == T_BR || op == T_BRL) begin
            tgt  = seq + 64'(longint'($signed(i_instr[25:0])) * 4);
            link = (op == T_BRL);
            e_tag = link ? "R4" : "R3";
        end else if ((op == T_EZ || op == T_NZ) && rsn == 5'd0) begin
            tgt  = i_rt_val + 64'(longint'($signed(i_instr[15:0])));
            link = (op == T_NZ);
            e_tag = link ? "R8" : "R6";
        end else if (op == T_EZ) begin
            if (i_rs_val == 64'd0) tgt = seq + 64'(longint'($signed(i_instr[20:0])) * 4);
            e_tag = "R5/R11";
        end else if (op == T_NZ) begin
            if (i_rs_val != 64'd0) tgt = seq + 64'(longint'($signed(i_instr[20:0])) * 4);
            e_tag = "R7/R11";
        end else begin
            e_tag = "R10";
        end
        e_valid = 1'b1;
        e_next  = tgt;
        e_redir = (tgt != seq);
        e_lwe   = link;
        e_lidx  = link ? 5'd31 : 5'd0;
        e_ldata = link ? seq : 64'd0;
        if (e_redir == 1'b0 && e_tag != "R10") e_tag = {e_tag, "/R9"};
    endtask

    task automatic check();
        compared++;
        if (o_valid !== e_valid || o_next_pc !== e_next || o_redirect !== e_redir ||
            o_link_we !== e_lwe || o_link_idx !== e_lidx || o_link_data !== e_ldata) begin
            mismatched++;
            $display("FAIL %s: actual v=%0b pc=%h rd=%0b we=%0b idx=%0d ld=%h expected v=%0b pc=%h rd=%0b we=%0b idx=%0d ld=%h",
                     e_tag, o_valid, o_next_pc, o_redirect, o_link_we, o_link_idx, o_link_data,
                     e_valid, e_next, e_redir, e_lwe, e_lidx, e_ldata);
        end
    endtask

    task automatic step(input logic r, input logic v, input logic [63:0] pc,
                        input logic [31:0] ins, input logic [63:0] rsv, input logic [63:0] rtv);
        @(negedge clk);
        check();
        rst = r; i_valid = v; i_pc = pc; i_instr = ins; i_rs_val = rsv; i_rt_val = rtv;
        model();
    endtask

    function automatic logic [31:0] mk26(input logic [5:0] op, input logic [25:0] off);
        return {op, off};
    endfunction

    function automatic logic [31:0] mk21(input logic [5:0] op, input logic [4:0] rs, input logic [20:0] off);
        return {op, rs, off};
    endfunction

    function automatic logic [31:0] mki(input logic [5:0] op, input logic [4:0] rt, input logic [15:0] imm);
        return {op, 5'd0, rt, imm};
    endfunction

    initial begin
        #(200000 * 5);
        mismatched++;
        $display("FAIL watchdog: actual still running, expected finished");
        summary();
        $finish;
    end

    initial begin
        model();
        // R1 reset state
        repeat (3) step(1'b1, 1'b1, 64'h1000, mk26(T_BR, 26'd8), 64'd0, 64'd0);
        // R2 idle cycle, even with a branch on the bus
        step(1'b0, 1'b0, 64'h1000, mk26(T_BR, 26'd8), 64'd0, 64'd0);
        // R3 forward, zero offset (R9), most negative offset
        step(1'b0, 1'b1, 64'h1000, mk26(T_BR, 26'd8), 64'd0, 64'd0);
        step(1'b0, 1'b1, 64'h2000, mk26(T_BR, 26'd0), 64'd0, 64'd0);
        step(1'b0, 1'b1, 64'h0800_0000, mk26(T_BR, 26'h200_0000), 64'd0, 64'd0);
        // R9 wrap at the top of the address space
        step(1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFC, mk26(T_BR, 26'd0), 64'd0, 64'd0);
        // R4 branch and link
        step(1'b0, 1'b1, 64'h4000, mk26(T_BRL, 26'h3FF_FFFF), 64'd5, 64'd6);
        // R5 taken / not taken, R11 no link
        step(1'b0, 1'b1, 64'h5000, mk21(T_EZ, 5'd7, 21'h10_0000), 64'd0, 64'd1);
        step(1'b0, 1'b1, 64'h5000, mk21(T_EZ, 5'd7, 21'h10_0000), 64'd1, 64'd0);
        // R6 indexed jump, negative immediate
        step(1'b0, 1'b1, 64'h6000, mki(T_EZ, 5'd3, 16'hFFFC), 64'd0, 64'h1000);
        // R7 taken / not taken
        step(1'b0, 1'b1, 64'h7000, mk21(T_NZ, 5'd2, 21'h0_0040), 64'd9, 64'd0);
        step(1'b0, 1'b1, 64'h7000, mk21(T_NZ, 5'd2, 21'h0_0040), 64'd0, 64'd9);
        // R8 indexed jump and link
        step(1'b0, 1'b1, 64'h8000, mki(T_NZ, 5'd4, 16'h0010), 64'd0, 64'h9000);
        // R10 unrelated opcode
        step(1'b0, 1'b1, 64'h9000, 32'h0000_0025, 64'd0, 64'd0);
        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w;
            logic [63:0] rsv;
            int pick;
            w    = $urandom;
            pick = $urandom_range(0, 5);
            case (pick)
                0: w[31:26] = T_BR;
                1: w[31:26] = T_BRL;
                2: w[31:26] = T_EZ;
                3: w[31:26] = T_NZ;
                default: ;
            endcase
            if ($urandom_range(0, 2) == 0) w[25:21] = 5'd0;
            rsv = ($urandom_range(0, 2) == 0) ? 64'd0 : {$urandom, $urandom};
            step(1'b0, ($urandom_range(0, 9) != 0), {$urandom, $urandom, 2'b00} >> 2 << 2,
                 w, rsv, {$urandom, $urandom});
        end
        step(1'b0, 1'b0, 64'd0, 32'd0, 64'd0, 64'd0);
        step(1'b0, 1'b0, 64'd0, 32'd0, 64'd0, 64'd0);
        summary();
        $finish;
    end
endmodule